// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block mirrors the tag and recency state of a K-way set-associative cache with true LRU replacement, over a small group of monitored sets. For every access it reports how deep in the recency stack of the addressed set the tag was found, or that it was absent. It holds no data, only tags, valid bits and their order.

Each reported depth is also counted in a histogram of K+1 bins. One bin exists for each recency depth and one for misses. Under LRU a smaller allocation always holds a subset of what a larger one holds. So the misses that an allocation of `a` ways would have suffered equal the sum of bins a+1 through K+1. Software or a partition controller can read the bins through a small index/data port and clear them all in one cycle.

Top module: `stack_dist_prof`

## Requirements
- R1: There are exactly WAYS+1 counters, read combinationally on `rd_count` by `rd_idx` values 1 to WAYS+1. Any other index reads 0. After reset every counter reads 0, and `res_valid` and `res_miss` are 0.
- R2: A hit on the line at recency depth i reports `res_pos` = i and `res_miss` = 0, and increments only counter i. Depth 1 is most recently used and depth WAYS is least recently used.
- R3: The accessed tag becomes depth 1. Lines that stood above it move down one depth, and lines below it keep their depth. An immediate repeat of an access reports depth 1.
- R4: A miss reports `res_miss` = 1 and `res_pos` = WAYS+1, and increments only counter WAYS+1. It inserts the tag at depth 1 and drops the line at depth WAYS.
- R5: After reset every line is invalid, and an invalid line never produces a hit, whatever its stored tag.
- R6: `res_valid`, `res_pos` and `res_miss` are registered. They belong to the access strobed one clock edge earlier. `res_valid` is high for exactly one cycle per access, and one access is accepted every cycle, including back to back.
- R7: A synchronous `clr` zeroes all counters at the next edge and leaves the tag state intact. When an access arrives in the same cycle, `clr` wins and the access leaves no count, although its result is still reported.
- R8: Counters are CNT_W bits wide (32 by default) and stick at 2^CNT_W-1 instead of wrapping.
- R9: Sets are independent: an access to one set never changes the order or contents of another.
- R10: For every allocation a from 1 to WAYS, the sum of counters a+1 to WAYS+1 equals the number of misses an a-way LRU cache would have seen on the same access stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Monitored set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| clr | input | 1 | Zero all counters |
| rd_idx | input | POS_W | Counter select, 1..WAYS+1 |
| res_valid | output | 1 | Result of previous-cycle access is present |
| res_miss | output | 1 | Previous access missed |
| res_pos | output | POS_W | Recency depth of previous access, WAYS+1 on miss |
| rd_count | output | CNT_W | Selected counter value |

## Verification
A strobed access is looked up before the rising edge and lands in the result registers and the counter bank on that same edge. The bench therefore drives each access on a falling edge and reads `res_*` on the next falling edge, which lets accesses run back to back. The counter readout is combinational on `rd_idx`, so it is read a few nanoseconds after the index changes while no access is strobed. A clear takes effect on one edge and is checked on the falling edge after it. The expected depth of each access comes from independent per-allocation LRU models in the bench, one for every size from 1 to WAYS.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Width able to hold depths 1..ways plus the miss code ways+1.
  function automatic int pos_bits(input int ways);
    return $clog2(ways + 2);
  endfunction

  // A line at depth index i (0 = MRU) moves down when i is within the shift span.
  function automatic bit moves_down(input int i, input int span);
    return (i != 0) && (i <= span);
  endfunction

endpackage

// File: rtl/lsd_set_stack.sv
module lsd_set_stack #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 16,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  localparam int IW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tags [WAYS];
  logic [WAYS-1:0]  vld;
  logic [IW-1:0]    hidx;
  logic [IW-1:0]    span;

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && vld[i] && tags[i] == tag) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
    end
    pos  = POS_W'(hidx) + POS_W'(1);
    span = hit ? hidx : IW'(WAYS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < WAYS; i++) tags[i] <= '0;
    end else if (upd) begin
      tags[0] <= tag;
      vld[0]  <= 1'b1;
      for (int i = 1; i < WAYS; i++) begin
        if (lsd_pkg::moves_down(i, int'(span))) begin
          tags[i] <= tags[i-1];
          vld[i]  <= vld[i-1];
        end
      end
    end
  end
endmodule

// File: rtl/lsd_hist.sv
module lsd_hist #(
  parameter int NB    = 9,
  parameter int CNT_W = 32,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [POS_W-1:0] bin,
  input  logic [POS_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_count
);
  logic [CNT_W-1:0] cnt [NB];

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int b = 0; b < NB; b++) cnt[b] <= '0;
    end else if (inc) begin
      for (int b = 0; b < NB; b++)
        if (int'(bin) == b + 1) cnt[b] <= sat_inc(cnt[b]);
    end
  end

  always_comb begin
    rd_count = '0;
    for (int b = 0; b < NB; b++)
      if (int'(rd_idx) == b + 1) rd_count = cnt[b];
  end
endmodule

// File: rtl/stack_dist_prof.sv
module stack_dist_prof #(
  parameter int WAYS  = 8,
  parameter int SETS  = 4,
  parameter int TAG_W = 16,
  parameter int CNT_W = 32,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int POS_W = lsd_pkg::pos_bits(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             clr,
  input  logic [POS_W-1:0] rd_idx,
  output logic             res_valid,
  output logic             res_miss,
  output logic [POS_W-1:0] res_pos,
  output logic [CNT_W-1:0] rd_count
);
  localparam logic [POS_W-1:0] MISS_POS = POS_W'(WAYS + 1);

  logic [SETS-1:0]  set_hit;
  logic [POS_W-1:0] set_pos [SETS];
  logic             look_hit;
  logic [POS_W-1:0] look_pos;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    lsd_set_stack #(.WAYS(WAYS), .TAG_W(TAG_W), .POS_W(POS_W)) u_stack (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (acc_valid && acc_set == SET_W'(s)),
      .tag  (acc_tag),
      .hit  (set_hit[s]),
      .pos  (set_pos[s])
    );
  end

  always_comb begin
    look_hit = 1'b0;
    look_pos = MISS_POS;
    for (int s = 0; s < SETS; s++) begin
      if (int'(acc_set) == s && set_hit[s]) begin
        look_hit = 1'b1;
        look_pos = set_pos[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_pos   <= '0;
    end else begin
      res_valid <= acc_valid;
      res_miss  <= acc_valid && !look_hit;
      if (acc_valid) res_pos <= look_pos;
    end
  end

  lsd_hist #(.NB(WAYS + 1), .CNT_W(CNT_W), .POS_W(POS_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .inc     (acc_valid),
    .bin     (look_pos),
    .rd_idx  (rd_idx),
    .rd_count(rd_count)
  );
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
  parameter int WAYS  = 8,
  parameter int SET_W = 2,
  parameter int TAG_W = 16,
  parameter int CNT_W = 32,
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic [TAG_W-1:0] acc_tag,
  input logic             clr,
  input logic [POS_W-1:0] rd_idx,
  input logic             res_valid,
  input logic             res_miss,
  input logic [POS_W-1:0] res_pos,
  input logic [CNT_W-1:0] rd_count,
  input logic             look_hit
);
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> res_pos == POS_W'(WAYS + 1)); // R4
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_miss) |-> (res_pos >= POS_W'(1) && res_pos <= POS_W'(WAYS))); // R2
  AST_LOOKUP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !look_hit) |=> res_miss); // R4
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid); // R6
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && !res_miss)); // R6
  AST_REPEAT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && acc_set == $past(acc_set) && acc_tag == $past(acc_tag))
    |=> (!res_miss && res_pos == POS_W'(1))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rd_count == '0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && $stable(rd_idx)) |-> rd_count >= $past(rd_count)); // R8
endmodule

bind stack_dist_prof lsd_checker #(
  .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_tag(acc_tag), .clr(clr), .rd_idx(rd_idx), .res_valid(res_valid),
  .res_miss(res_miss), .res_pos(res_pos), .rd_count(rd_count), .look_hit(look_hit)
);

// File: tb/sim_stack_dist_prof.sv
`timescale 1ns/1ps
module sim_stack_dist_prof;
  localparam int W = 4;
  localparam int S = 2;
  localparam int T = 3;
  localparam int C = 6;
  localparam int SW = 1;
  localparam int PW = $clog2(W + 2);
  localparam int CMAX = (1 << C) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [T-1:0] acc_tag = '0;
  logic clr = 1'b0;
  logic [PW-1:0] rd_idx = '0;
  logic res_valid, res_miss;
  logic [PW-1:0] res_pos;
  logic [C-1:0] rd_count;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [T-1:0] mt [1:W][0:S-1][0:W-1];
  bit           mv [1:W][0:S-1][0:W-1];
  int cnt_m [1:W+1];
  int miss_m [1:W];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  stack_dist_prof #(.WAYS(W), .SETS(S), .TAG_W(T), .CNT_W(C)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_tag(acc_tag), .clr(clr), .rd_idx(rd_idx), .res_valid(res_valid),
    .res_miss(res_miss), .res_pos(res_pos), .rd_count(rd_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void zero_counts();
    for (int i = 1; i <= W + 1; i++) cnt_m[i] = 0;
    for (int a = 1; a <= W; a++) miss_m[a] = 0;
  endfunction

  // Updates every per-allocation LRU model; returns depth in the W-way one.
  function automatic int model_access(input int s, input int t);
    int depth = W + 1;
    for (int a = 1; a <= W; a++) begin
      int k = -1;
      int span;
      for (int j = 0; j < a; j++)
        if (k < 0 && mv[a][s][j] && mt[a][s][j] == T'(t)) k = j;
      if (a == W) depth = (k < 0) ? W + 1 : k + 1;
      if (k < 0) miss_m[a]++;
      span = (k < 0) ? a - 1 : k;
      for (int j = span; j >= 1; j--) begin
        mt[a][s][j] = mt[a][s][j-1];
        mv[a][s][j] = mv[a][s][j-1];
      end
      mt[a][s][0] = T'(t);
      mv[a][s][0] = 1'b1;
    end
    return depth;
  endfunction

  // Called at a falling edge; leaves the strobe high so calls run back to back.
  task automatic access(input string req, input int s, input int t, input bit with_clr = 0);
    int p;
    acc_valid = 1'b1; acc_set = SW'(s); acc_tag = T'(t); clr = with_clr;
    p = model_access(s, t);
    if (with_clr) zero_counts();
    else if (cnt_m[p] < CMAX) cnt_m[p]++;
    @(negedge clk);
    chk(req, int'(res_valid), 1);
    chk(req, int'(res_miss), (p == W + 1) ? 1 : 0);
    chk(req, int'(res_pos), p);
  endtask

  task automatic idle();
    acc_valid = 1'b0; clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_cnt(input int idx, output int val);
    rd_idx = PW'(idx);
    #1;
    val = int'(rd_count);
  endtask

  task automatic check_hist(input string req);
    int v;
    acc_valid = 1'b0; clr = 1'b0;
    for (int i = 0; i < (1 << PW); i++) begin
      read_cnt(i, v);
      chk(req, v, (i >= 1 && i <= W + 1) ? cnt_m[i] : 0);
    end
    @(negedge clk);
  endtask

  task automatic do_clear();
    acc_valid = 1'b0; clr = 1'b1;
    zero_counts();
    @(negedge clk);
    clr = 1'b0;
  endtask

  function automatic int rnd(input int mod);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr) % mod;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    int sum;
    for (int a = 1; a <= W; a++)
      for (int s = 0; s < S; s++)
        for (int j = 0; j < W; j++) begin mv[a][s][j] = 0; mt[a][s][j] = '0; end
    zero_counts();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", int'(res_valid), 0);
    chk("R1 reset miss", int'(res_miss), 0);
    check_hist("R1 reset counters");
    // R5: stored tags reset to 0 but are invalid
    access("R5 invalid no hit", 0, 0);
    access("R3 repeat is MRU", 0, 0);
    access("R4 fill", 0, 1);
    access("R4 fill", 0, 2);
    access("R4 fill", 0, 3);
    access("R2 hit at LRU depth", 0, 0);
    access("R2 hit mid depth", 0, 2);
    access("R4 evict", 0, 4);
    access("R4 evicted tag misses", 0, 1);
    idle();
    chk("R6 idle no result", int'(res_valid), 0);
    check_hist("R1 counter bins");
    // R9: other set holds nothing yet
    access("R9 set isolation", 1, 2);
    access("R9 set0 intact", 0, 1);
    idle();
    // R7: clear keeps tags
    do_clear();
    check_hist("R7 cleared");
    access("R7 tags kept", 0, 1);
    idle();
    // R10: short stream, miss sums per allocation
    do_clear();
    for (int n = 0; n < 50; n++) access("R2 short stream", rnd(S), rnd(6));
    check_hist("R2 short histogram");
    for (int a = 1; a <= W; a++) begin
      sum = 0;
      for (int i = a + 1; i <= W + 1; i++) begin read_cnt(i, v); sum += v; end
      chk("R10 miss sum", sum, miss_m[a]);
    end
    @(negedge clk);
    // R7: clear wins over simultaneous access
    access("R7 clear with access", 0, 2, 1);
    idle();
    check_hist("R7 clear priority");
    // R8: saturation
    for (int n = 0; n < CMAX + 8; n++) access("R8 repeat", 1, 5);
    idle();
    read_cnt(1, v);
    chk("R8 saturated", v, CMAX);
    @(negedge clk);
    // long sweep with periodic histogram comparison
    do_clear();
    for (int n = 0; n < 2000; n++) begin
      access("R3 sweep", rnd(S), rnd(7));
      if (n % 250 == 249) check_hist("R8 sweep histogram");
    end
    idle();
    check_hist("R2 final histogram");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule